// File: doc/BRIEF.md
# Time-Slot Switch Processor Access Decoder

This block sits between a simple synchronous processor bus and the storage of a time-slot switch. Each access carries an 8-bit address. The top address bit picks one of two regions. With that bit low, the lower seven bits select a small set of configuration registers. With that bit high, the lower seven bits select one of 128 locations inside a window onto a large memory. The window's upper address bits come from a stream field held in the control register. A memory-select bit in the same register sends the window either to the connection memory or to the data memory.

The bus is non-multiplexed. The processor raises chip select and strobe, with the direction, address and write data held stable, and keeps them until the acknowledge appears. It then drops the strobe. Each strobe period results in exactly one access. The memories live outside the block. They are reached through address, strobe and data ports, and each has a one-cycle registered read. Targets that are read-only accept a write without changing anything, and the write is still acknowledged.

Top module: `tsw_uport_decode`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, busAck is low, busRdata is zero, all memory strobes are low, and every configuration field (stream, memory select, block-program bit, mode fields, frame offset) is zero.
- R2: busAck goes high in the cycle after a cycle in which busSel and busStrobe are both high. It stays high while both remain high, and it goes low in the cycle after either one drops. A strobe held over many cycles performs exactly one access, in its first cycle.
- R3: The control register is at offset 0, with the address top bit low. Bits 3:0 hold the stream field (ctrlStream), bit 4 is memory select (ctrlMemSel, 0 = connection memory, 1 = data memory) and bit 5 is the block-program bit (ctrlBlockProg). It is read/write, and its other bits read as zero.
- R4: The interface-mode register is at offset 1. Bits 4:0 hold block-program data, bit 5 is block-program enable, bit 6 is output standby, bit 7 is start-frame evaluation and bits 9:8 are the data rate. It is read/write, and its other bits read as zero.
- R5: The frame-offset register is at offset 3. It is a full 16-bit read/write register shown on frameOffset, and it changes only on the first cycle of a write access to it.
- R6: Offset 2 returns the frameAlign input as it stood in the first cycle of the read. Writes to it change nothing.
- R7: Register offsets 4 to 127 read as zero, and writes to them change no register.
- R8: A windowed access with memory select 0 pulses connRd (read) or connWr (write) for exactly the first cycle of the access. In that cycle connAddr = {stream, address bits 6:0} and connWdata = busWdata. Read data is taken from connRdata while busAck is high.
- R9: A windowed read with memory select 1 pulses dataRd for the first cycle, with dataAddr = {stream, address bits 6:0}. busRdata follows dataRdata while busAck is high.
- R10: A windowed write with memory select 1 produces no memory strobe at all and is still acknowledged as in R2.
- R11: busRdata is zero whenever busAck is low and during the acknowledge of any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Chip select |
| busStrobe | input | 1 | Access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Bit 7 selects the window, bits 6:0 give the offset |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid while busAck is high |
| busAck | output | 1 | Transfer acknowledge |
| connAddr | output | 11 | Connection memory address |
| connRd | output | 1 | Connection memory read strobe |
| connWr | output | 1 | Connection memory write strobe |
| connWdata | output | 16 | Connection memory write data |
| connRdata | input | 16 | Connection memory read data, one cycle after connRd |
| dataAddr | output | 11 | Data memory address |
| dataRd | output | 1 | Data memory read strobe |
| dataRdata | input | 16 | Data memory read data, one cycle after dataRd |
| frameAlign | input | 16 | Frame alignment value, read-only |
| ctrlStream | output | 4 | Stream field of the control register |
| ctrlMemSel | output | 1 | Memory select |
| ctrlBlockProg | output | 1 | Block-program bit |
| modeBpData | output | 5 | Block-program data |
| modeBpEn | output | 1 | Block-program enable |
| modeStandby | output | 1 | Output standby |
| modeFrameEval | output | 1 | Start-frame evaluation |
| modeRate | output | 2 | Data-rate select |
| frameOffset | output | 16 | Frame input offset register |

## Verification
The assertions assume a well-behaved bus master. The master changes busWrite, busAddr and busWdata only while the strobe is low, and it never raises the strobe again in the cycle right after the acknowledge has dropped it. The strobe-uniqueness and stability properties depend on this. The stimulus drives every input one time unit after a rising edge, from a single access task. That task holds all request fields constant from the start of the strobe until its release, and the stimulus includes chip-select-free strobes and immediate back-to-back accesses. The memories are modelled in the bench as registered-read arrays, with the same one-cycle latency that the decoder expects.

// File: rtl/tsw_uport_pkg.sv
package tsw_uport_pkg;
  localparam int OFFS_CTRL   = 0;
  localparam int OFFS_MODE   = 1;
  localparam int OFFS_ALIGN  = 2;
  localparam int OFFS_OFFSET = 3;

  // where the data of the access in progress comes from
  typedef enum logic [1:0] {SRC_NONE, SRC_REG, SRC_CONN, SRC_DATA} rdSrc_e;

  // one-cycle strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;
    logic ctrlWr;
    logic modeWr;
    logic offsWr;
    logic connRd;
    logic connWr;
    logic dataRd;
  } accStrobe_t;
endpackage

// File: rtl/tsw_uport_seq.sv
module tsw_uport_seq
  import tsw_uport_pkg::*;
#(
  parameter int WIN_BITS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busSel,
  input  logic                busStrobe,
  input  logic                busWrite,
  input  logic [WIN_BITS:0]   busAddr,
  input  logic                memSel,
  output accStrobe_t          stb,
  output logic                ack
);
  logic ackQ;
  logic reqActive;
  logic start;
  logic winHit;
  logic [WIN_BITS-1:0] offs;

  assign reqActive = busSel & busStrobe;
  assign start     = reqActive & ~ackQ;
  assign winHit    = busAddr[WIN_BITS];
  assign offs      = busAddr[WIN_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ackQ <= 1'b0;
    else        ackQ <= reqActive;
  end

  always_comb begin
    stb         = '0;
    stb.capture = start & ~busWrite;
    stb.ctrlWr  = start & busWrite & ~winHit & (offs == WIN_BITS'(OFFS_CTRL));
    stb.modeWr  = start & busWrite & ~winHit & (offs == WIN_BITS'(OFFS_MODE));
    stb.offsWr  = start & busWrite & ~winHit & (offs == WIN_BITS'(OFFS_OFFSET));
    stb.connRd  = start & ~busWrite & winHit & ~memSel;
    stb.connWr  = start & busWrite & winHit & ~memSel;
    stb.dataRd  = start & ~busWrite & winHit & memSel;
  end

  assign ack = ackQ;
endmodule

// File: rtl/tsw_uport_regs.sv
module tsw_uport_regs
  import tsw_uport_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int WIN_BITS    = 7,
  parameter int STREAM_BITS = 4,
  localparam int MEM_AW     = STREAM_BITS + WIN_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  accStrobe_t             stb,
  input  logic                   ack,
  input  logic [WIN_BITS:0]      busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  input  logic [DATA_W-1:0]      connRdata,
  input  logic [DATA_W-1:0]      dataRdata,
  input  logic [DATA_W-1:0]      frameAlign,
  output logic [DATA_W-1:0]      busRdata,
  output logic [MEM_AW-1:0]      memAddr,
  output logic [STREAM_BITS-1:0] stream,
  output logic                   memSel,
  output logic                   blockProg,
  output logic [4:0]             bpData,
  output logic                   bpEn,
  output logic                   standby,
  output logic                   frameEval,
  output logic [1:0]             rate,
  output logic [DATA_W-1:0]      frameOffset
);
  logic [WIN_BITS-1:0] offs;
  logic [DATA_W-1:0]   regView;
  logic [DATA_W-1:0]   holdQ;
  rdSrc_e              srcQ;

  assign offs    = busAddr[WIN_BITS-1:0];
  assign memAddr = {stream, offs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stream <= '0; memSel <= 1'b0; blockProg <= 1'b0;
      bpData <= '0; bpEn <= 1'b0; standby <= 1'b0; frameEval <= 1'b0; rate <= '0;
      frameOffset <= '0;
    end else begin
      if (stb.ctrlWr) begin
        stream    <= busWdata[STREAM_BITS-1:0];
        memSel    <= busWdata[STREAM_BITS];
        blockProg <= busWdata[STREAM_BITS+1];
      end
      if (stb.modeWr) begin
        bpData    <= busWdata[4:0];
        bpEn      <= busWdata[5];
        standby   <= busWdata[6];
        frameEval <= busWdata[7];
        rate      <= busWdata[9:8];
      end
      if (stb.offsWr) frameOffset <= busWdata;
    end
  end

  always_comb begin
    regView = '0;
    case (offs)
      WIN_BITS'(OFFS_CTRL):   regView = DATA_W'({blockProg, memSel, stream});
      WIN_BITS'(OFFS_MODE):   regView = DATA_W'({rate, frameEval, standby, bpEn, bpData});
      WIN_BITS'(OFFS_ALIGN):  regView = frameAlign;
      WIN_BITS'(OFFS_OFFSET): regView = frameOffset;
      default:                regView = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcQ  <= SRC_NONE;
      holdQ <= '0;
    end else if (stb.capture) begin
      holdQ <= regView;
      if (stb.connRd)      srcQ <= SRC_CONN;
      else if (stb.dataRd) srcQ <= SRC_DATA;
      else                 srcQ <= SRC_REG;
    end else if (stb.connWr | stb.ctrlWr | stb.modeWr | stb.offsWr |
                 (ack == 1'b0)) begin
      srcQ <= SRC_NONE;
    end
  end

  always_comb begin
    busRdata = '0;
    if (ack) begin
      case (srcQ)
        SRC_REG:  busRdata = holdQ;
        SRC_CONN: busRdata = connRdata;
        SRC_DATA: busRdata = dataRdata;
        default:  busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tsw_uport_decode.sv
module tsw_uport_decode
  import tsw_uport_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int WIN_BITS    = 7,
  parameter int STREAM_BITS = 4,
  localparam int MEM_AW     = STREAM_BITS + WIN_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   busSel,
  input  logic                   busStrobe,
  input  logic                   busWrite,
  input  logic [WIN_BITS:0]      busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  output logic                   busAck,
  output logic [MEM_AW-1:0]      connAddr,
  output logic                   connRd,
  output logic                   connWr,
  output logic [DATA_W-1:0]      connWdata,
  input  logic [DATA_W-1:0]      connRdata,
  output logic [MEM_AW-1:0]      dataAddr,
  output logic                   dataRd,
  input  logic [DATA_W-1:0]      dataRdata,
  input  logic [DATA_W-1:0]      frameAlign,
  output logic [STREAM_BITS-1:0] ctrlStream,
  output logic                   ctrlMemSel,
  output logic                   ctrlBlockProg,
  output logic [4:0]             modeBpData,
  output logic                   modeBpEn,
  output logic                   modeStandby,
  output logic                   modeFrameEval,
  output logic [1:0]             modeRate,
  output logic [DATA_W-1:0]      frameOffset
);
  accStrobe_t        stb;
  logic [MEM_AW-1:0] memAddr;

  tsw_uport_seq #(.WIN_BITS(WIN_BITS)) seq_i (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busStrobe(busStrobe),
    .busWrite(busWrite), .busAddr(busAddr), .memSel(ctrlMemSel),
    .stb(stb), .ack(busAck)
  );

  tsw_uport_regs #(.DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .STREAM_BITS(STREAM_BITS)) regs_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .ack(busAck), .busAddr(busAddr),
    .busWdata(busWdata), .connRdata(connRdata), .dataRdata(dataRdata),
    .frameAlign(frameAlign), .busRdata(busRdata), .memAddr(memAddr),
    .stream(ctrlStream), .memSel(ctrlMemSel), .blockProg(ctrlBlockProg),
    .bpData(modeBpData), .bpEn(modeBpEn), .standby(modeStandby),
    .frameEval(modeFrameEval), .rate(modeRate), .frameOffset(frameOffset)
  );

  assign connAddr  = memAddr;
  assign dataAddr  = memAddr;
  assign connWdata = busWdata;
  assign connRd    = stb.connRd;
  assign connWr    = stb.connWr;
  assign dataRd    = stb.dataRd;
endmodule

// File: rtl/tsw_uport_decode_chk.sv
module tsw_uport_decode_chk #(
  parameter int DATA_W      = 16,
  parameter int STREAM_BITS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busSel,
  input logic                   busStrobe,
  input logic                   busWrite,
  input logic                   busAck,
  input logic [DATA_W-1:0]      busRdata,
  input logic                   connRd,
  input logic                   connWr,
  input logic                   dataRd,
  input logic [DATA_W-1:0]      frameOffset,
  input logic [STREAM_BITS-1:0] ctrlStream
);
  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busSel && busStrobe) |=> busAck); // R2
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !(busSel && busStrobe) |=> !busAck); // R2
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({connRd, connWr, dataRd}) <= 1); // R8
  AST_STROBE_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (connRd || connWr || dataRd) |-> !busAck); // R8
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (connRd || connWr || dataRd) |=> !(connRd || connWr || dataRd)); // R8
  AST_NO_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dataRd |-> !busWrite); // R10
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busAck |-> (busRdata == '0)); // R11
  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(busSel && busStrobe && busWrite) |=> $stable(frameOffset)); // R5
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(busSel && busStrobe && busWrite) |=> $stable(ctrlStream)); // R3
endmodule

bind tsw_uport_decode tsw_uport_decode_chk #(.DATA_W(DATA_W), .STREAM_BITS(STREAM_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .busSel(busSel), .busStrobe(busStrobe),
  .busWrite(busWrite), .busAck(busAck), .busRdata(busRdata),
  .connRd(connRd), .connWr(connWr), .dataRd(dataRd),
  .frameOffset(frameOffset), .ctrlStream(ctrlStream)
);

// File: tb/tsw_uport_decode_tb_top.sv
module tsw_uport_decode_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busSel = 1'b0, busStrobe = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busAck;
  logic [10:0] connAddr, dataAddr;
  logic        connRd, connWr, dataRd;
  logic [15:0] connWdata;
  logic [15:0] connRdata = '0, dataRdata = '0;
  logic [15:0] frameAlign = 16'h0000;
  logic [3:0]  ctrlStream;
  logic        ctrlMemSel, ctrlBlockProg;
  logic [4:0]  modeBpData;
  logic        modeBpEn, modeStandby, modeFrameEval;
  logic [1:0]  modeRate;
  logic [15:0] frameOffset;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsw_uport_decode dut_i (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busStrobe(busStrobe),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busAck(busAck), .connAddr(connAddr),
    .connRd(connRd), .connWr(connWr), .connWdata(connWdata),
    .connRdata(connRdata), .dataAddr(dataAddr), .dataRd(dataRd),
    .dataRdata(dataRdata), .frameAlign(frameAlign), .ctrlStream(ctrlStream),
    .ctrlMemSel(ctrlMemSel), .ctrlBlockProg(ctrlBlockProg),
    .modeBpData(modeBpData), .modeBpEn(modeBpEn), .modeStandby(modeStandby),
    .modeFrameEval(modeFrameEval), .modeRate(modeRate), .frameOffset(frameOffset)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // behavioural reference state
  int    mAck = 0, mStream = 0, mMemSel = 0, mBp = 0;
  int    mMode = 0, mOffs = 0;
  int    mHold = 0;
  int    mSrc = 0;          // 0 none, 1 register, 2 connection, 3 data
  string mTag = "R11";
  int    connMem [2048];

  // values seen at the last falling edge
  int lRst = 0, lSel = 0, lStb = 0, lWr = 0, lAddr = 0, lWd = 0, lAlign = 0;
  int lConnRd = 0, lConnWr = 0, lDataRd = 0, lMemAddr = 0;

  function automatic int dataVal(input int a);
    return ((a * 16'h0101) ^ 16'h5A5A) & 16'hFFFF;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int start, win, offs, wr, expRd;
    string rdTag, dTag;
    if (!done) begin
      vectors++;
      if (!rst_n) begin
        cmp("R1", "busAck", busAck, 0);
        cmp("R1", "busRdata", busRdata, 0);
        cmp("R1", "strobes", {connRd, connWr, dataRd}, 0);
        cmp("R1", "ctrl", {ctrlBlockProg, ctrlMemSel, ctrlStream}, 0);
        cmp("R1", "mode", {modeRate, modeFrameEval, modeStandby, modeBpEn, modeBpData}, 0);
        cmp("R1", "frameOffset", frameOffset, 0);
      end else begin
        start = busSel & busStrobe & (mAck == 0);
        win   = busAddr[7];
        offs  = busAddr[6:0];
        wr    = busWrite;
        cmp("R2", "busAck", busAck, mAck);
        cmp("R8", "connRd", connRd, start & ~wr & win & (mMemSel == 0));
        cmp("R8", "connWr", connWr, start & wr & win & (mMemSel == 0));
        dTag = wr ? "R10" : "R9";
        cmp(dTag, "dataRd", dataRd, start & ~wr & win & (mMemSel == 1));
        if (start && win && mMemSel == 0) begin
          cmp("R8", "connAddr", connAddr, mStream * 128 + offs);
          if (wr) cmp("R8", "connWdata", connWdata, busWdata);
        end
        if (start && win && mMemSel == 1 && !wr)
          cmp("R9", "dataAddr", dataAddr, mStream * 128 + offs);
        expRd = 0; rdTag = "R11";
        if (mAck != 0) begin
          rdTag = mTag;
          if (mSrc == 1) expRd = mHold;
          else if (mSrc == 2) expRd = connRdata;
          else if (mSrc == 3) expRd = dataRdata;
        end
        cmp(rdTag, "busRdata", busRdata, expRd);
        cmp("R3/R7", "ctrl fields", {ctrlBlockProg, ctrlMemSel, ctrlStream},
            mBp * 32 + mMemSel * 16 + mStream);
        cmp("R4/R7", "mode fields", {modeRate, modeFrameEval, modeStandby, modeBpEn, modeBpData},
            mMode);
        cmp("R5/R7", "frameOffset", frameOffset, mOffs);
      end
      lRst = rst_n; lSel = busSel; lStb = busStrobe; lWr = busWrite;
      lAddr = busAddr; lWd = busWdata; lAlign = frameAlign;
      lConnRd = connRd; lConnWr = connWr; lDataRd = dataRd; lMemAddr = connAddr;
    end
  end

  always @(posedge clk) begin
    int start, offs;
    // external memories with one-cycle registered read
    if (lConnWr != 0) connMem[lMemAddr] = lWd[15:0];
    if (lConnRd != 0) connRdata = connMem[lMemAddr][15:0];
    if (lDataRd != 0) dataRdata = dataVal(lMemAddr);
    if (lRst == 0) begin
      mAck = 0; mStream = 0; mMemSel = 0; mBp = 0; mMode = 0; mOffs = 0;
      mSrc = 0; mHold = 0; mTag = "R11";
    end else begin
      start = lSel & lStb & (mAck == 0);
      offs  = lAddr & 127;
      if (start) begin
        if (lWr != 0) begin
          mSrc = 0; mTag = "R11";
          if (lAddr < 128) begin
            if (offs == 0) begin
              mStream = lWd & 15; mMemSel = (lWd >> 4) & 1; mBp = (lWd >> 5) & 1;
            end else if (offs == 1) mMode = lWd & 16'h03FF;
            else if (offs == 3) mOffs = lWd;
          end
        end else if (lAddr >= 128) begin
          mSrc = (mMemSel == 0) ? 2 : 3;
          mTag = (mMemSel == 0) ? "R8" : "R9";
        end else begin
          mSrc = 1;
          case (offs)
            0: begin mHold = mBp * 32 + mMemSel * 16 + mStream; mTag = "R3"; end
            1: begin mHold = mMode; mTag = "R4"; end
            2: begin mHold = lAlign; mTag = "R6"; end
            3: begin mHold = mOffs; mTag = "R5"; end
            default: begin mHold = 0; mTag = "R7"; end
          endcase
        end
      end
      mAck = lSel & lStb;
    end
  end

  task automatic access(input bit wr, input int addr, input int wd, input int hold);
    @(posedge clk); #1;
    busSel = 1'b1; busStrobe = 1'b1; busWrite = wr;
    busAddr = addr[7:0]; busWdata = wd[15:0];
    repeat (1 + hold) @(posedge clk);
    #1; busSel = 1'b0; busStrobe = 1'b0;
  endtask

  task automatic strobeNoSel(input int addr);
    @(posedge clk); #1;
    busSel = 1'b0; busStrobe = 1'b1; busWrite = 1'b1;
    busAddr = addr[7:0]; busWdata = 16'hFFFF;
    repeat (2) @(posedge clk);
    #1; busStrobe = 1'b0;
  endtask

  task automatic finishRun;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int lfsr;
    for (int i = 0; i < 2048; i++) connMem[i] = 0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // R3 control register write and readback
    access(1, 8'h00, 16'h0005, 0);
    access(0, 8'h00, 0, 0);
    // R8 connection memory window, stream 5
    access(1, 8'h8A, 16'hBEEF, 0);
    access(1, 8'h8B, 16'h1234, 2);
    access(0, 8'h8A, 0, 0);
    access(0, 8'h8B, 0, 3);
    // switch stream: same offset must address another location
    access(1, 8'h00, 16'h0002, 0);
    access(0, 8'h8A, 0, 0);
    access(1, 8'h8A, 16'hCAFE, 0);
    access(0, 8'h8A, 0, 0);
    // R4 mode register, upper bits dropped
    access(1, 8'h01, 16'hFFFF, 0);
    access(0, 8'h01, 0, 0);
    access(1, 8'h01, 16'h0155, 0);
    access(0, 8'h01, 0, 1);
    // R5 frame offset
    access(1, 8'h03, 16'h1357, 0);
    access(0, 8'h03, 0, 0);
    // R6 frame alignment read-only
    frameAlign = 16'hA5C3;
    access(0, 8'h02, 0, 0);
    access(1, 8'h02, 16'h0000, 0);
    access(0, 8'h02, 0, 0);
    // R7 unmapped offsets
    access(1, 8'h04, 16'hFFFF, 0);
    access(1, 8'h7F, 16'hFFFF, 0);
    access(0, 8'h04, 0, 0);
    access(0, 8'h7F, 0, 0);
    // R3 all control bits, data memory selected
    access(1, 8'h00, 16'hFFFF, 0);
    access(0, 8'h00, 0, 0);
    // R9 data memory read, R10 data memory write ignored
    access(0, 8'h85, 0, 0);
    access(1, 8'h85, 16'h9999, 1);
    access(0, 8'hFF, 0, 2);
    // R2 strobe without chip select
    strobeNoSel(8'h03);
    access(0, 8'h03, 0, 0);
    // mixed traffic
    lfsr = 32'h1ACE;
    for (int k = 0; k < 400; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      frameAlign = lfsr[15:0];
      if ((lfsr & 15) == 0)
        access(1, 8'h00, (lfsr >> 4) & 16'h003F, 0);
      else
        access(lfsr[4], {lfsr[5], 2'b00, lfsr[10:6]}, lfsr[15:0] ^ k, lfsr[12:11]);
    end
    repeat (4) @(posedge clk);
    // R1 reset mid-run returns every field to zero
    #1; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1'b1;
    repeat (3) @(posedge clk);
    finishRun();
  end
endmodule